// File: doc/BRIEF.md
# Power-Pulse Cycle Sequencer

This block opens a periodic power window for a chain of front-end readout chips and decides when triggers may be taken. Each cycle it moves through four phases. In IDLE the pulsed supplies are off. In WAKE the supplies are on but the chips still hold no usable data, so triggers stay masked. In ACQ acquisition is enabled and triggers are accepted. In READ the chain is being read out. Three supply domains are driven separately: analog, threshold DAC and digital. The digital domain stays powered through readout so that the readout clock buffers keep running. Any domain can be taken out of pulsing and kept permanently powered.

The period, the length of the power window and the wake interval are register inputs, counted in system clock cycles. The block samples them only while it is idle. The wake interval it applies is never shorter than the settling time of the slowest pulsed domain. Both settling times are fixed parameters. The block exposes the number of triggers accepted in the current cycle. It leaves ACQ for READ only when that number is non-zero. A synchronous, active-high reset drops every supply, raises the veto and returns the block to IDLE.

Typical settings are a 2 ms window in a 10 ms period, or a 1 ms window in a 200 ms period. The user converts these times into clock counts.

Top module: `pwr_pulse_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the cycle after that edge shows `pwr_en` = 0, `veto` = 1, `acq_en` = 0, `trig_out` = 0, `trig_count` = 0 and `phase` = IDLE. This holds whatever `cfg_keep_on` is.
- R2: `phase` is coded IDLE=0, WAKE=1, ACQ=2, READ=3. The named transitions are:
  - start: IDLE to WAKE
  - settled: WAKE to ACQ
  - close-hit: ACQ to READ, when at least one trigger was accepted this cycle
  - close-empty: ACQ to IDLE, when no trigger was accepted
  - drained: READ to IDLE, on `readout_done`
- R3: WAKE begins every `cfg_period` cycles when readout finishes in time. WAKE and ACQ together last `cfg_on_time` cycles, counted from the first WAKE cycle (`cfg_on_time` must exceed the wake length).
- R4: WAKE lasts the largest of three values: `cfg_wake`, `ANA_SETTLE` when the analog domain is pulsed, and `DAC_SETTLE` when the DAC domain is pulsed.
- R5: `pwr_en` bit 0 is analog, bit 1 is DAC and bit 2 is digital. A pulsed analog or DAC domain is on in WAKE and ACQ only. A pulsed digital domain is on in WAKE, ACQ and READ. A domain whose `cfg_keep_on` bit is 1 is on whenever `rst` is low.
- R6: `acq_en` is high only in ACQ. `veto` is its complement, so triggers are masked in IDLE, WAKE, READ and reset.
- R7: A trigger is a rising edge of `trig_in`: high on this clock edge and low on the previous one. A trigger seen in ACQ gives `trig_out` high for exactly the next cycle and adds one to `trig_count`. A trigger seen in any other phase changes neither.
- R8: `trig_count` clears when WAKE begins and saturates at its maximum.
- R9: `cfg_on_time`, `cfg_wake` and `cfg_period` are sampled only in IDLE. A change made in WAKE, ACQ or READ does not alter the cycle in progress.
- R10: When `readout_done` arrives after the period has already elapsed, WAKE begins on the cycle right after the return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_period | input | CNT_W | Cycles from one WAKE start to the next |
| cfg_on_time | input | CNT_W | Cycles of WAKE plus ACQ |
| cfg_wake | input | CNT_W | Requested wake interval in cycles |
| cfg_keep_on | input | 3 | Per-domain always-on selection (1 = not pulsed) |
| trig_in | input | 1 | Raw trigger request |
| readout_done | input | 1 | Readout chain has finished |
| pwr_en | output | 3 | Supply enables: analog, DAC, digital |
| acq_en | output | 1 | Acquisition enable |
| veto | output | 1 | Trigger veto / busy |
| trig_out | output | 1 | One-cycle pulse per accepted trigger |
| trig_count | output | TCNT_W | Triggers accepted this cycle |
| phase | output | 2 | Current phase code |

## Verification
The assertions assume three things about the inputs:
- `cfg_keep_on` stays constant for a whole power cycle. The wake-length check recomputes the settling need from the live mask.
- `cfg_on_time` is larger than the effective wake length and smaller than `cfg_period`.
- Reset is held for several cycles at start-up.

The stimulus changes the mask only while the block is IDLE. It keeps the on time above every wake length it programs. It pulses `readout_done` only in READ. Configuration is also written in the middle of a cycle, on purpose, to show that those writes take effect only after the next IDLE.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAKE = 2'd1,
        PH_ACQ  = 2'd2,
        PH_READ = 2'd3
    } pps_phase_e;

    localparam int NUM_DOM = 3;
    localparam int DOM_ANA = 0;
    localparam int DOM_DAC = 1;
    localparam int DOM_DIG = 2;

endpackage

// File: rtl/pps_wake_calc.sv
module pps_wake_calc
    import pps_pkg::*;
#(
    parameter int CNT_W      = 26,
    parameter int ANA_SETTLE = 1600,
    parameter int DAC_SETTLE = 5000
) (
    input  logic [CNT_W-1:0]   cfg_wake,
    input  logic [NUM_DOM-1:0] keep_on,
    output logic [CNT_W-1:0]   wake_eff
);

    localparam logic [CNT_W-1:0] ANA_C = CNT_W'(ANA_SETTLE);
    localparam logic [CNT_W-1:0] DAC_C = CNT_W'(DAC_SETTLE);

    logic [CNT_W-1:0] ana_need;
    logic [CNT_W-1:0] dac_need;
    logic [CNT_W-1:0] dom_need;

    // a domain kept permanently on needs no settling time inside the cycle
    always_comb begin
        ana_need = keep_on[DOM_ANA] ? '0 : ANA_C;
        dac_need = keep_on[DOM_DAC] ? '0 : DAC_C;
        dom_need = (ana_need > dac_need) ? ana_need : dac_need;
        wake_eff = (cfg_wake > dom_need) ? cfg_wake : dom_need;
    end

endmodule

// File: rtl/pps_dom_gate.sv
module pps_dom_gate #(
    parameter bit ON_IN_READ = 1'b0
) (
    input  logic rst,
    input  logic keep_on,
    input  logic pulse_on,
    input  logic read_on,
    output logic en
);

    always_comb begin
        en = !rst && (keep_on || pulse_on || (ON_IN_READ && read_on));
    end

endmodule

// File: rtl/pps_trig_gate.sv
module pps_trig_gate #(
    parameter int TCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    input  logic              window,
    input  logic              clear,
    output logic              accept,
    output logic              trig_out,
    output logic [TCNT_W-1:0] count
);

    logic trig_d;

    always_comb begin
        accept = window && trig_in && !trig_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_d   <= 1'b0;
            trig_out <= 1'b0;
            count    <= '0;
        end else begin
            trig_d   <= trig_in;
            trig_out <= accept;
            if (clear) begin
                count <= '0;
            end else if (accept && !(&count)) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwr_pulse_seq.sv
module pwr_pulse_seq
    import pps_pkg::*;
#(
    parameter int CNT_W      = 26,
    parameter int TCNT_W     = 8,
    parameter int ANA_SETTLE = 1600,
    parameter int DAC_SETTLE = 5000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   cfg_period,
    input  logic [CNT_W-1:0]   cfg_on_time,
    input  logic [CNT_W-1:0]   cfg_wake,
    input  logic [2:0]         cfg_keep_on,
    input  logic               trig_in,
    input  logic               readout_done,
    output logic [2:0]         pwr_en,
    output logic               acq_en,
    output logic               veto,
    output logic               trig_out,
    output logic [TCNT_W-1:0]  trig_count,
    output logic [1:0]         phase
);

    localparam int EW = CNT_W + 1;

    pps_phase_e       state;
    pps_phase_e       state_n;
    logic [CNT_W-1:0] tmr;
    logic [CNT_W-1:0] on_q;
    logic [CNT_W-1:0] wake_q;
    logic [CNT_W-1:0] wake_eff;
    logic [EW-1:0]    tmr_nx;
    logic             idle_done;
    logic             wake_done;
    logic             on_done;
    logic             start_cyc;
    logic             accept;
    logic             have_trig;
    logic             pulse_on;
    logic             read_on;

    pps_wake_calc #(
        .CNT_W      (CNT_W),
        .ANA_SETTLE (ANA_SETTLE),
        .DAC_SETTLE (DAC_SETTLE)
    ) u_wake (
        .cfg_wake (cfg_wake),
        .keep_on  (cfg_keep_on),
        .wake_eff (wake_eff)
    );

    // timer runs from the first WAKE cycle; a count of N ends on value N-1
    always_comb begin
        tmr_nx    = {1'b0, tmr} + EW'(1);
        idle_done = tmr_nx >= {1'b0, cfg_period};
        wake_done = tmr_nx >= {1'b0, wake_q};
        on_done   = tmr_nx >= {1'b0, on_q};
        start_cyc = (state == PH_IDLE) && idle_done;
        have_trig = (trig_count != '0) || accept;
    end

    // next-state selection
    always_comb begin
        state_n = state;
        unique case (state)
            PH_IDLE: if (idle_done)    state_n = PH_WAKE;
            PH_WAKE: if (wake_done)    state_n = PH_ACQ;
            PH_ACQ:  if (on_done)      state_n = have_trig ? PH_READ : PH_IDLE;
            PH_READ: if (readout_done) state_n = PH_IDLE;
            default:                   state_n = PH_IDLE;
        endcase
    end

    // state register, cycle timer and idle-time sampling of the settings
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PH_IDLE;
            tmr    <= '0;
            on_q   <= '0;
            wake_q <= '0;
        end else begin
            state <= state_n;
            if (start_cyc) begin
                tmr <= '0;
            end else if (!(&tmr)) begin
                tmr <= tmr + 1'b1;
            end
            if (state == PH_IDLE) begin
                on_q   <= cfg_on_time;
                wake_q <= wake_eff;
            end
        end
    end

    // outputs decoded from the phase
    always_comb begin
        pulse_on = !rst && ((state == PH_WAKE) || (state == PH_ACQ));
        read_on  = !rst && (state == PH_READ);
        acq_en   = !rst && (state == PH_ACQ);
        veto     = !acq_en;
        phase    = state;
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pps_dom_gate #(
            .ON_IN_READ (d == DOM_DIG)
        ) u_gate (
            .rst      (rst),
            .keep_on  (cfg_keep_on[d]),
            .pulse_on (pulse_on),
            .read_on  (read_on),
            .en       (pwr_en[d])
        );
    end

    pps_trig_gate #(
        .TCNT_W (TCNT_W)
    ) u_trig (
        .clk      (clk),
        .rst      (rst),
        .trig_in  (trig_in),
        .window   (acq_en),
        .clear    (start_cyc),
        .accept   (accept),
        .trig_out (trig_out),
        .count    (trig_count)
    );

endmodule

// File: rtl/pps_check.sv
module pps_check
    import pps_pkg::*;
#(
    parameter int CNT_W      = 26,
    parameter int TCNT_W     = 8,
    parameter int ANA_SETTLE = 1600,
    parameter int DAC_SETTLE = 5000
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cfg_keep_on,
    input logic [2:0]        pwr_en,
    input logic              acq_en,
    input logic              veto,
    input logic              trig_out,
    input logic [TCNT_W-1:0] trig_count,
    input logic [1:0]        phase
);

    localparam logic [CNT_W-1:0] ANA_C = CNT_W'(ANA_SETTLE);
    localparam logic [CNT_W-1:0] DAC_C = CNT_W'(DAC_SETTLE);

    logic [CNT_W-1:0] wk_len;
    logic [CNT_W-1:0] need;

    always_ff @(posedge clk) begin
        if (rst) begin
            wk_len <= '0;
        end else if (phase == PH_WAKE) begin
            wk_len <= wk_len + 1'b1;
        end else begin
            wk_len <= '0;
        end
    end

    always_comb begin
        need = '0;
        if (!cfg_keep_on[DOM_ANA] && ANA_C > need) need = ANA_C;
        if (!cfg_keep_on[DOM_DAC] && DAC_C > need) need = DAC_C;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (phase == PH_IDLE && trig_count == '0 && !trig_out));

    assert_idle_next_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> (phase == PH_IDLE || phase == PH_WAKE));

    assert_wake_next_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAKE) |=> (phase == PH_WAKE || phase == PH_ACQ));

    assert_read_next_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ) |=> (phase == PH_READ || phase == PH_IDLE));

    assert_wake_len_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACQ && $past(phase) == PH_WAKE) |-> (wk_len >= need));

    assert_read_dig_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ) |-> pwr_en[DOM_DIG]);

    assert_read_ana_off_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ && !cfg_keep_on[DOM_ANA]) |-> !pwr_en[DOM_ANA]);

    assert_veto_acq_R6: assert property (@(posedge clk) disable iff (rst)
        veto == !acq_en);

    assert_wake_vetoed_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAKE) |-> veto);

    assert_trig_single_R7: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);

    assert_trig_window_R7: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> $past(acq_en));

    assert_count_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAKE && $past(phase) == PH_IDLE) |-> (trig_count == '0));

endmodule

bind pwr_pulse_seq pps_check #(
    .CNT_W      (CNT_W),
    .TCNT_W     (TCNT_W),
    .ANA_SETTLE (ANA_SETTLE),
    .DAC_SETTLE (DAC_SETTLE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_keep_on (cfg_keep_on),
    .pwr_en      (pwr_en),
    .acq_en      (acq_en),
    .veto        (veto),
    .trig_out    (trig_out),
    .trig_count  (trig_count),
    .phase       (phase)
);

// File: tb/sim_pwr_pulse_seq.sv
`timescale 1ns/100ps
module sim_pwr_pulse_seq;

    localparam int CW = 16;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] cfg_period;
    logic [CW-1:0] cfg_on_time;
    logic [CW-1:0] cfg_wake;
    logic [2:0]    cfg_keep_on;
    logic          trig_in;
    logic          readout_done;
    logic [2:0]    pwr_en;
    logic          acq_en;
    logic          veto;
    logic          trig_out;
    logic [TW-1:0] trig_count;
    logic [1:0]    phase;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pwr_pulse_seq #(
        .CNT_W(CW), .TCNT_W(TW), .ANA_SETTLE(8), .DAC_SETTLE(25)
    ) u0 (
        .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_on_time(cfg_on_time),
        .cfg_wake(cfg_wake), .cfg_keep_on(cfg_keep_on), .trig_in(trig_in),
        .readout_done(readout_done), .pwr_en(pwr_en), .acq_en(acq_en), .veto(veto),
        .trig_out(trig_out), .trig_count(trig_count), .phase(phase)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_for(input logic [1:0] p, input string req);
        int g = 0;
        while (phase != p && g < 4000) begin
            @(negedge clk);
            g++;
        end
        chk(req, "reached phase", int'(phase), int'(p));
    endtask

    task automatic run_len(input logic [1:0] p, output int n);
        n = 0;
        while (phase == p && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_keep_on = 3'b111; trig_in = 1'b0; readout_done = 1'b0;
        cfg_period = 200; cfg_on_time = 60; cfg_wake = 40;
        repeat (4) @(negedge clk);
        chk("R1", "pwr_en in reset", int'(pwr_en), 0);
        chk("R1", "veto in reset", int'(veto), 1);
        chk("R1", "acq_en in reset", int'(acq_en), 0);
        chk("R1", "trig_count in reset", int'(trig_count), 0);
        chk("R1", "phase in reset", int'(phase), 0);
        cfg_keep_on = 3'b000;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "idle after reset", int'(phase), 0);
        chk("R5", "pulsed domains off in idle", int'(pwr_en), 0);
    endtask

    task automatic t_basic_cycle();
        int n;
        wait_for(2'd1, "R2");
        chk("R5", "all pulsed domains on in wake", int'(pwr_en), 7);
        chk("R6", "veto in wake", int'(veto), 1);
        run_len(2'd1, n);
        chk("R4", "wake length from cfg_wake", n, 40);
        chk("R2", "settled to acq", int'(phase), 2);
        chk("R6", "acq_en in acq", int'(acq_en), 1);
        chk("R6", "veto in acq", int'(veto), 0);
        run_len(2'd2, n);
        chk("R3", "acq length", n, 20);
        chk("R2", "empty window returns to idle", int'(phase), 0);
        chk("R5", "domains off after window", int'(pwr_en), 0);
        run_len(2'd0, n);
        chk("R3", "idle length to next start", n, 140);
    endtask

    task automatic t_triggers();
        int n;
        bit seen = 1'b0;
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        while (phase == 2'd1) begin
            if (trig_out) seen = 1'b1;
            @(negedge clk);
        end
        chk("R7", "no trig_out during wake", int'(seen), 0);
        chk("R7", "no count from wake trigger", int'(trig_count), 0);
        trig_in = 1'b1;
        @(negedge clk);
        chk("R7", "trig_out after acq edge", int'(trig_out), 1);
        chk("R7", "count after first trigger", int'(trig_count), 1);
        trig_in = 1'b0;
        @(negedge clk);
        chk("R7", "trig_out lasts one cycle", int'(trig_out), 0);
        trig_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7", "held trigger gives single pulse", int'(trig_out), 0);
        trig_in = 1'b0;
        @(negedge clk);
        chk("R7", "held trigger counted once", int'(trig_count), 2);
        run_len(2'd2, n);
        chk("R2", "window with hits goes to read", int'(phase), 3);
        chk("R5", "only digital on in read", int'(pwr_en), 4);
        chk("R6", "veto in read", int'(veto), 1);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk("R7", "read trigger gives no pulse", int'(trig_out), 0);
        chk("R7", "read trigger not counted", int'(trig_count), 2);
        repeat (3) @(negedge clk);
        chk("R2", "read held without done", int'(phase), 3);
        readout_done = 1'b1;
        @(negedge clk);
        readout_done = 1'b0;
        chk("R2", "drained to idle", int'(phase), 0);
        wait_for(2'd1, "R2");
        chk("R8", "count cleared at wake start", int'(trig_count), 0);
    endtask

    task automatic t_config_and_clamp();
        int n;
        cfg_wake = 5;
        run_len(2'd1, n);
        chk("R9", "wake unchanged by mid-cycle write", n, 40);
        cfg_on_time = 100;
        run_len(2'd2, n);
        chk("R9", "window unchanged by mid-cycle write", n, 20);
        cfg_on_time = 60;
        wait_for(2'd1, "R2");
        run_len(2'd1, n);
        chk("R4", "wake clamped to DAC settle", n, 25);
        run_len(2'd2, n);
        chk("R3", "acq after clamped wake", n, 35);
        cfg_keep_on = 3'b010;
        @(negedge clk);
        chk("R5", "kept DAC on in idle", int'(pwr_en), 2);
        wait_for(2'd1, "R2");
        run_len(2'd1, n);
        chk("R4", "wake clamped to analog settle", n, 8);
        run_len(2'd2, n);
        cfg_keep_on = 3'b011;
        @(negedge clk);
        chk("R5", "kept analog and DAC on in idle", int'(pwr_en), 3);
        wait_for(2'd1, "R2");
        run_len(2'd1, n);
        chk("R4", "wake from cfg_wake when nothing to settle", n, 5);
        run_len(2'd2, n);
        cfg_keep_on = 3'b000;
        cfg_wake = 40;
    endtask

    task automatic t_late_readout();
        int n;
        wait_for(2'd2, "R2");
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        run_len(2'd2, n);
        chk("R2", "late case enters read", int'(phase), 3);
        repeat (160) @(negedge clk);
        readout_done = 1'b1;
        @(negedge clk);
        readout_done = 1'b0;
        chk("R10", "back to idle after late readout", int'(phase), 0);
        run_len(2'd0, n);
        chk("R10", "idle of one cycle after late readout", n, 1);
        chk("R10", "wake follows at once", int'(phase), 1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_cycle();
        t_triggers();
        t_config_and_clamp();
        t_late_readout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule